// File: doc/BRIEF.md
# Timer/Counter with Assignable Prescaler

This block is an 8-bit up-counter that runs either from an internal tick or from edges seen on an external pin. The internal tick comes once every four system clocks. The external pin is first synchronised to the system clock. Its active edge, rising or falling, is picked by a configuration bit. Either source can be passed straight to the counter, or routed through an 8-bit prescaler. The prescaler divides the source by a power of two from 2 to 256, chosen by a 3-bit ratio field.

Software reads the count and loads a new value over a simple register bus. Each load also restarts the prescaler. When the count rolls over from its top value to zero, the block sets a sticky flag for the interrupt controller. The flag stays set until software clears it.

Top module: `tmr0_prescale`

## Requirements
- R1: After reset the count is 00h and the overflow flag is 0.
- R2: With srcExt=0 and psToTimer=0, the count increases by one at every fourth rising clock edge. The internal phase counter starts at zero at reset, so the first increment lands on the fourth clock edge after reset is released.
- R3: With psToTimer=1, the count increases once per 2^(psRatio+1) source ticks. psRatio=0 gives 2 and psRatio=7 gives 256. The prescaler counts source ticks from zero and emits a tick when its low psRatio+1 bits are all ones.
- R4: With srcExt=1, edgeFall=0 counts rising edges of extPin and edgeFall=1 counts falling edges. A pin change made before clock edge k is counted at clock edge k+2.
- R5: In counter mode each detected edge gives at most one source tick. A pin held at a constant level adds nothing.
- R6: A counter tick at count FFh makes the count 00h and sets the overflow flag.
- R7: The overflow flag stays set until flagClr is high at a clock edge. If an overflow happens in the same cycle as flagClr, the flag is set.
- R8: When wrEn is high at a clock edge, the count takes wrData and the prescaler count returns to zero.
- R9: A write takes priority over a tick in the same cycle. The count takes wrData, and no overflow is flagged.
- R10: The input that is not selected by srcExt has no effect. Pin edges are ignored in timer mode, and internal ticks are ignored in counter mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| extPin | input | 1 | External count input, asynchronous |
| srcExt | input | 1 | 1 selects pin edges as the source, 0 selects the internal divide-by-4 tick |
| edgeFall | input | 1 | 1 counts falling pin edges, 0 counts rising pin edges |
| psToTimer | input | 1 | 1 routes the source through the prescaler |
| psRatio | input | 3 | Prescale select: the ratio is 2^(psRatio+1) |
| wrEn | input | 1 | Load strobe for the count |
| wrData | input | 8 | Value to load |
| flagClr | input | 1 | Clears the overflow flag |
| rdData | output | 8 | Current count |
| ovfFlag | output | 1 | Sticky overflow flag |

## Verification
Loads and flag clears are visible right after the clock edge at which they are sampled. An internal tick moves the count at every fourth edge after reset, and a pin edge reaches the count two edges after the one that first samples it. The bench drives inputs on the falling edge. A cycle model is stepped on each rising edge, using the same delays taken from the requirements. The count and flag are compared against that model on the following falling edge, so every result is sampled one half period after the edge that is due to produce it.

// File: rtl/tmr0_pkg.sv
package tmr0_pkg;
  typedef struct packed {
    logic load;
    logic tick;
  } tmr_strb_t;
endpackage

// File: rtl/tmr0_src.sv
module tmr0_src #(
  parameter int BASE_DIV = 4,
  parameter int SYNC_N   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic extPin,
  input  logic srcExt,
  input  logic edgeFall,
  output logic srcTick
);
  localparam int PH_W = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;

  logic [PH_W-1:0] phase;
  logic [SYNC_N:0] sh;
  logic baseInt, extEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= '0;
    else if (phase == PH_W'(BASE_DIV - 1)) phase <= '0;
    else phase <= phase + 1'b1;
  end

  for (genvar i = 0; i <= SYNC_N; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) sh[0] <= 1'b0;
        else sh[0] <= extPin;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) sh[i] <= 1'b0;
        else sh[i] <= sh[i-1];
    end
  end

  assign baseInt = (phase == PH_W'(BASE_DIV - 1));
  assign extEdge = edgeFall ? (sh[SYNC_N] & ~sh[SYNC_N-1])
                            : (~sh[SYNC_N] & sh[SYNC_N-1]);
  assign srcTick = srcExt ? extEdge : baseInt;

  // R2: internal ticks never come on adjacent cycles
  p_int_spacing_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!srcExt && srcTick) |=> !baseInt);
  // R5: a single edge never yields two ticks back to back
  p_one_per_edge_r5: assert property (@(posedge clk) disable iff (!rstN)
    (srcExt && $stable(srcExt) && $stable(edgeFall) && extEdge) |=> !extEdge);
endmodule

// File: rtl/tmr0_ctrl.sv
module tmr0_ctrl
  import tmr0_pkg::*;
#(
  parameter int PS_SEL_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                srcTick,
  input  logic                psToTimer,
  input  logic [PS_SEL_W-1:0] psRatio,
  input  logic                wrEn,
  output tmr_strb_t           strb
);
  localparam int PS_W = 1 << PS_SEL_W;

  logic [PS_W-1:0] psCnt;
  logic [PS_W:0]   maskWide;
  logic [PS_W-1:0] mask;
  logic            psHit;

  always_comb begin
    maskWide = ((PS_W+1)'(1) << (int'(psRatio) + 1)) - (PS_W+1)'(1);
    mask     = maskWide[PS_W-1:0];
    psHit    = ((psCnt & mask) == mask);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) psCnt <= '0;
    else if (wrEn) psCnt <= '0;
    else if (psToTimer && srcTick) psCnt <= psCnt + 1'b1;
  end

  assign strb.load = wrEn;
  assign strb.tick = srcTick && (!psToTimer || psHit);

  // R8: a load restarts the prescaler
  p_ps_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (psCnt == '0));
  // R3: a prescaled tick only follows at least two source ticks
  p_ps_min_r3: assert property (@(posedge clk) disable iff (!rstN)
    (psToTimer && strb.tick) |-> (psCnt[0] == 1'b1));
endmodule

// File: rtl/tmr0_dp.sv
module tmr0_dp
  import tmr0_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmr_strb_t        strb,
  input  logic [CNT_W-1:0] wrData,
  input  logic             flagClr,
  output logic [CNT_W-1:0] count,
  output logic             ovfFlag
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic rollOver;
  assign rollOver = strb.tick && !strb.load && (count == TOP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) count <= '0;
    else if (strb.load) count <= wrData;
    else if (strb.tick) count <= count + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ovfFlag <= 1'b0;
    else if (rollOver) ovfFlag <= 1'b1;
    else if (flagClr) ovfFlag <= 1'b0;
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.tick) |=> $stable(count));
  p_inc_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !strb.load) |=> (count == $past(count) + 1'b1));
  p_load_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (count == $past(wrData)));
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !strb.load && count == TOP) |=> (ovfFlag && count == '0));
  p_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !flagClr) |=> ovfFlag);
endmodule

// File: rtl/tmr0_prescale.sv
module tmr0_prescale
  import tmr0_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int PS_SEL_W = 3,
  parameter int BASE_DIV = 4,
  parameter int SYNC_N   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                extPin,
  input  logic                srcExt,
  input  logic                edgeFall,
  input  logic                psToTimer,
  input  logic [PS_SEL_W-1:0] psRatio,
  input  logic                wrEn,
  input  logic [CNT_W-1:0]    wrData,
  input  logic                flagClr,
  output logic [CNT_W-1:0]    rdData,
  output logic                ovfFlag
);
  logic      srcTick;
  tmr_strb_t strb;

  tmr0_src #(.BASE_DIV(BASE_DIV), .SYNC_N(SYNC_N)) u_src (
    .clk(clk), .rstN(rstN), .extPin(extPin), .srcExt(srcExt),
    .edgeFall(edgeFall), .srcTick(srcTick)
  );

  tmr0_ctrl #(.PS_SEL_W(PS_SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .psToTimer(psToTimer),
    .psRatio(psRatio), .wrEn(wrEn), .strb(strb)
  );

  tmr0_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .flagClr(flagClr), .count(rdData), .ovfFlag(ovfFlag)
  );
endmodule

// File: tb/tmr0_prescale_bench.sv
module tmr0_prescale_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extPin = 1'b0, srcExt = 1'b0, edgeFall = 1'b0, psToTimer = 1'b0;
  logic [2:0] psRatio = 3'd0;
  logic wrEn = 1'b0, flagClr = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic ovfFlag;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";

  // model state
  logic [1:0] mPhase;
  logic m1, m2, m3;
  logic [7:0] mPs, mCnt;
  logic mFlag;

  always #2 clk = ~clk;

  tmr0_prescale u_tmr0_prescale (
    .clk(clk), .rstN(rstN), .extPin(extPin), .srcExt(srcExt),
    .edgeFall(edgeFall), .psToTimer(psToTimer), .psRatio(psRatio),
    .wrEn(wrEn), .wrData(wrData), .flagClr(flagClr),
    .rdData(rdData), .ovfFlag(ovfFlag)
  );

  function automatic logic [7:0] psMask(input logic [2:0] r);
    return 8'((9'd1 << (int'(r) + 1)) - 9'd1);
  endfunction

  function automatic logic srcEvent(input logic ext, input logic fall,
                                    input logic newS, input logic oldS,
                                    input logic [1:0] ph);
    if (ext) return fall ? (oldS & ~newS) : (~oldS & newS);
    return ph == 2'd3;
  endfunction

  always @(posedge clk) begin
    logic base, tick;
    if (!rstN) begin
      mPhase = 0; m1 = 0; m2 = 0; m3 = 0; mPs = 0; mCnt = 0; mFlag = 0;
    end else begin
      base = srcEvent(srcExt, edgeFall, m2, m3, mPhase);
      tick = base && (!psToTimer || ((mPs & psMask(psRatio)) == psMask(psRatio)));
      if (wrEn) mPs = 0;
      else if (psToTimer && base) mPs = mPs + 1;
      if (tick && !wrEn && mCnt == 8'hFF) mFlag = 1;
      else if (flagClr) mFlag = 0;
      if (wrEn) mCnt = wrData;
      else if (tick) mCnt = mCnt + 1;
      m3 = m2; m2 = m1; m1 = extPin;
      mPhase = mPhase + 1;
    end
  end

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", curReq, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check(rdData, mCnt, "count");
    check({7'd0, ovfFlag}, {7'd0, mFlag}, "flag");
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic doWrite(input logic [7:0] v);
    wrEn = 1; wrData = v; step(); wrEn = 0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      extPin = ~extPin; run(3);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    curReq = "R1";
    check(rdData, 8'h00, "reset count");
    check({7'd0, ovfFlag}, 8'h00, "reset flag");
    rstN = 1;
    curReq = "R2"; run(3);
    check(rdData, 8'h00, "before 4th edge");
    step();
    check(rdData, 8'h01, "at 4th edge");
    run(40);
    curReq = "R10"; for (int i = 0; i < 12; i++) begin extPin = ~extPin; step(); end
    curReq = "R3";
    for (int r = 0; r < 8; r++) begin
      psRatio = 3'(r); psToTimer = 1; doWrite(8'h10); run(4 * (2 << r) + 9);
    end
    psToTimer = 0;
    curReq = "R6"; doWrite(8'hFD); run(16);
    check({7'd0, ovfFlag}, 8'h01, "flag after wrap");
    curReq = "R7"; run(20);
    check({7'd0, ovfFlag}, 8'h01, "flag held");
    flagClr = 1; step(); flagClr = 0;
    check({7'd0, ovfFlag}, 8'h00, "flag cleared");
    doWrite(8'hFF); run(2); flagClr = 1; run(2); flagClr = 0; step();
    curReq = "R9";
    while (u_tmr0_prescale_phase_hint() != 1'b1) step();
    doWrite(8'hFF); check(rdData, 8'hFF, "write beat tick");
    run(8);
    curReq = "R4"; srcExt = 1; edgeFall = 0; extPin = 0; run(4); doWrite(8'h20);
    extPin = 1; run(2);
    check(rdData, 8'h20, "rising not yet");
    step(); check(rdData, 8'h21, "rising counted");
    extPin = 0; run(4); check(rdData, 8'h21, "falling ignored");
    edgeFall = 1; run(3); pulses(6);
    curReq = "R5"; extPin = 1; run(30); check(rdData, mCnt, "held pin");
    curReq = "R10"; run(50);
    curReq = "R8"; psToTimer = 1; psRatio = 3'd2; pulses(5); doWrite(8'h40); pulses(15);
    curReq = "R3";
    for (int i = 0; i < 4000; i++) begin
      if (i % 250 == 0) begin
        srcExt = 1'($urandom); edgeFall = 1'($urandom);
        psToTimer = 1'($urandom); psRatio = 3'($urandom_range(0, 3));
      end
      extPin = ($urandom_range(0, 3) == 0) ? ~extPin : extPin;
      flagClr = ($urandom_range(0, 15) == 0);
      wrEn = ($urandom_range(0, 47) == 0);
      wrData = ($urandom_range(0, 1) == 1) ? 8'hFE : 8'($urandom);
      step();
    end
    wrEn = 0; flagClr = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  // R9: the bench targets the cycle where an internal tick is due,
  // known from its own model phase (3 = tick at the coming edge)
  function automatic logic u_tmr0_prescale_phase_hint();
    return mPhase == 2'd3;
  endfunction

  initial begin
    void'($urandom(32'd1234));
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule